// File: doc/BRIEF.md
# Second-Order Incremental Decimation Filter

This block turns the one-bit output of a second-order incremental delta-sigma modulator into one fixed-point word per conversion. A start pulse clears the filter state, at the same moment as the modulator integrators are cleared. The filter then accepts a fixed number of qualified bitstream samples. It feeds them through two cascaded accumulators: the first integrates the signed bits and the second integrates the first. After the last sample, the final second-stage sum is normalised by a short sequential divider into an unsigned Q1.15 fraction, and a one-cycle valid strobe marks it.

In a temperature sensor, the modulator balances a scaled bipolar voltage difference against a base-emitter voltage. The output word is then the weighted ones-density that a host maps, through its calibration fit, to the ratio 3·dVBE/VBE and on to degrees. With the default length of 512 samples, the second-order weighting gives the word at least 15 fractional bits of resolution.

Top module: `incr_decim2`

## Requirements
- R1: After reset, `result` is 0 and `result_valid` is low.
- R2: Bit value 1 is taken as +1 and value 0 as -1 into the first accumulator, and the second accumulator adds the updated first-stage value on every accepted bit. The delivered word is floor(W·2^15 / F). Here W is the sum over accepted bits i = 0..N-1 (i in arrival order) of bit_i·(N-i), N is the conversion length and F = N(N+1)/2.
- R3: A conversion of all ones yields 0x8000 (1.0 in Q1.15), and one of all zeros yields 0x0000. No result ever exceeds 0x8000.
- R4: Only cycles with `bit_valid` high are counted, and idle gaps do not alter the result. Exactly N accepted bits finish a conversion, so N-1 bits produce no result.
- R5: `result_valid` is high for exactly one clock. It rises on the 17th rising edge after the edge that accepts the final bit, which is one transfer edge plus 16 divider steps.
- R6: Bits offered while no conversion is running are ignored. `result` holds its value until the next completed conversion.
- R7: A `start` pulse at any time aborts the conversion or division in progress and clears both accumulators. It restarts the sample count, and the aborted work never produces a `result_valid`.
- R8: When `start` and `bit_valid` are high in the same cycle, the restart takes effect and that bit is dropped.
- R9: Neither accumulator leaves its full-scale range: the first stays within ±N and the second within ±F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the filter state and begins a new conversion |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Modulator output bit |
| result | output | FRAC_W+1 | Unsigned Q1.15 conversion result, held between conversions |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The main path is tried with first-order density patterns (all ones, all zeros, half, and irregular fractions), which check the weighted sum against the closed form. Patterns with a single one at the first or last position, or a single zero at the first position, separate the weights of early and late bits: a filter that weighted bits evenly or in reverse order gives a different word. Runs with idle gaps between valid bits compare the result with the gap-free result. Directed sequences cover aborts during accumulation and during division, a restart that coincides with a valid bit, a truncated conversion, and bits offered while idle.

// File: rtl/incr_decim2_pkg.sv
package incr_decim2_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Full-scale magnitude of the second-stage sum for a conversion of n bits.
    function automatic int unsigned tri_number(input int unsigned n);
        return (n * (n + 1)) / 2;
    endfunction

    // Signed width able to hold values in [-v, v].
    function automatic int unsigned signed_width(input int unsigned v);
        return $clog2(v + 1) + 1;
    endfunction

endpackage

// File: rtl/incr_decim2_seq.sv
module incr_decim2_seq
    import incr_decim2_pkg::*;
#(
    parameter int unsigned CONV_LEN = 512,
    parameter int unsigned CNT_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_valid,
    output logic             step,
    output logic             clear,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic last;

    always_comb begin
        s_d   = s_q;
        s_d.done = 1'b0;
        clear = start;
        step  = (s_q.phase == PH_RUN) && bit_valid && !start;
        last  = step && (s_q.cnt == CNT_W'(CONV_LEN - 1));

        if (start) begin
            s_d.phase = PH_RUN;
            s_d.cnt   = '0;
        end else if (step) begin
            if (last) begin
                s_d.phase = PH_IDLE;
                s_d.cnt   = '0;
                s_d.done  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done  = s_q.done;
    assign count = s_q.cnt;

endmodule

// File: rtl/incr_decim2_cascade.sv
module incr_decim2_cascade #(
    parameter int unsigned ACC1_W = 11,
    parameter int unsigned ACC2_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              bit_in,
    output logic [ACC1_W-1:0] acc1,
    output logic [ACC2_W-1:0] acc2
);

    typedef struct packed {
        logic [ACC1_W-1:0] acc1;
        logic [ACC2_W-1:0] acc2;
    } cas_t;

    cas_t s_d, s_q;
    logic [ACC1_W-1:0] delta;
    logic [ACC1_W-1:0] acc1_upd;
    logic [ACC2_W-1:0] acc1_ext;

    always_comb begin
        s_d      = s_q;
        delta    = bit_in ? ACC1_W'(1) : '1;
        acc1_upd = s_q.acc1 + delta;
        acc1_ext = {{(ACC2_W - ACC1_W){acc1_upd[ACC1_W-1]}}, acc1_upd};

        if (clear) begin
            s_d.acc1 = '0;
            s_d.acc2 = '0;
        end else if (step) begin
            s_d.acc1 = acc1_upd;
            s_d.acc2 = s_q.acc2 + acc1_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc1 = s_q.acc1;
    assign acc2 = s_q.acc2;

endmodule

// File: rtl/incr_decim2_div.sv
module incr_decim2_div #(
    parameter int unsigned ACC2_W = 19,
    parameter int unsigned FULL   = 131328,
    parameter int unsigned Q_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              load,
    input  logic [ACC2_W-1:0] acc2,
    output logic [Q_W-1:0]    quot,
    output logic              valid
);

    localparam int unsigned IDX_W = $clog2(Q_W);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [ACC2_W-1:0] rem;
        logic [Q_W-1:0]    q;
        logic [Q_W-1:0]    res;
        logic              vld;
    } div_t;

    div_t s_d, s_q;
    logic [ACC2_W:0]   biased;
    logic [ACC2_W-1:0] weight;
    logic              ge;
    logic [ACC2_W-1:0] rem_sub;
    logic [Q_W-1:0]    q_next;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;

        // Shift the signed sum into [0, 2F]; half of it is the ones-weight.
        biased  = {acc2[ACC2_W-1], acc2} + (ACC2_W + 1)'(FULL);
        weight  = biased[ACC2_W:1];

        ge      = (s_q.rem >= ACC2_W'(FULL));
        rem_sub = ge ? (s_q.rem - ACC2_W'(FULL)) : s_q.rem;
        q_next  = {s_q.q[Q_W-2:0], ge};

        if (abort) begin
            s_d.busy = 1'b0;
        end else if (load) begin
            s_d.busy = 1'b1;
            s_d.idx  = IDX_W'(Q_W - 1);
            s_d.rem  = weight;
            s_d.q    = '0;
        end else if (s_q.busy) begin
            s_d.q   = q_next;
            s_d.rem = rem_sub << 1;
            if (s_q.idx == '0) begin
                s_d.busy = 1'b0;
                s_d.res  = q_next;
                s_d.vld  = 1'b1;
            end else begin
                s_d.idx = s_q.idx - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign quot  = s_q.res;
    assign valid = s_q.vld;

endmodule

// File: rtl/incr_decim2.sv
module incr_decim2
    import incr_decim2_pkg::*;
#(
    parameter int unsigned CONV_LEN = 512,
    parameter int unsigned FRAC_W   = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          bit_valid,
    input  logic          bit_in,
    output logic [FRAC_W:0] result,
    output logic          result_valid
);

    localparam int unsigned FULL   = tri_number(CONV_LEN);
    localparam int unsigned CNT_W  = $clog2(CONV_LEN + 1);
    localparam int unsigned ACC1_W = signed_width(CONV_LEN);
    localparam int unsigned ACC2_W = signed_width(FULL);
    localparam int unsigned Q_W    = FRAC_W + 1;

    logic              step_w;
    logic              clear_w;
    logic              done_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [ACC1_W-1:0] acc1_w;
    logic [ACC2_W-1:0] acc2_w;

    incr_decim2_seq #(
        .CONV_LEN (CONV_LEN),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bit_valid (bit_valid),
        .step      (step_w),
        .clear     (clear_w),
        .done      (done_w),
        .count     (cnt_w)
    );

    incr_decim2_cascade #(
        .ACC1_W (ACC1_W),
        .ACC2_W (ACC2_W)
    ) u_cascade (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_w),
        .step   (step_w),
        .bit_in (bit_in),
        .acc1   (acc1_w),
        .acc2   (acc2_w)
    );

    incr_decim2_div #(
        .ACC2_W (ACC2_W),
        .FULL   (FULL),
        .Q_W    (Q_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (start),
        .load  (done_w),
        .acc2  (acc2_w),
        .quot  (result),
        .valid (result_valid)
    );

endmodule

// File: rtl/incr_decim2_chk.sv
module incr_decim2_chk
    import incr_decim2_pkg::*;
#(
    parameter int unsigned CONV_LEN = 512,
    parameter int unsigned FRAC_W   = 15
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  start,
    input logic [FRAC_W:0]                       result,
    input logic                                  result_valid,
    input logic [signed_width(CONV_LEN)-1:0]     acc1,
    input logic [signed_width(tri_number(CONV_LEN))-1:0] acc2,
    input logic [$clog2(CONV_LEN + 1)-1:0]       cnt
);

    localparam int FULL_I = int'(tri_number(CONV_LEN));
    localparam int LEN_I  = int'(CONV_LEN);
    localparam int ONE_I  = 1 << FRAC_W;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R5

    AST_RESULT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (int'(result) <= ONE_I)); // R3

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> result_valid); // R6

    AST_START_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !result_valid); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc1 == '0 && acc2 == '0 && cnt == '0)); // R7

    AST_ACC1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($signed(acc1)) <= LEN_I) && (int'($signed(acc1)) >= -LEN_I)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($signed(acc2)) <= FULL_I) && (int'($signed(acc2)) >= -FULL_I)); // R9

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < LEN_I); // R4

endmodule

bind incr_decim2 incr_decim2_chk #(
    .CONV_LEN (CONV_LEN),
    .FRAC_W   (FRAC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .result       (result),
    .result_valid (result_valid),
    .acc1         (acc1_w),
    .acc2         (acc2_w),
    .cnt          (cnt_w)
);

// File: tb/incr_decim2_test.sv
module incr_decim2_test;

    localparam int LEN     = 512;
    localparam longint FS  = (LEN * (LEN + 1)) / 2;
    localparam int LATENCY = 17;
    localparam int NVEC    = 8;

    typedef struct packed {
        logic [1:0]  mode;   // 0: density param/256, 1: single one at param, 2: single zero at param
        logic [9:0]  param;
        logic [3:0]  gap;
        logic [7:0]  req;    // requirement number named in messages
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 10'd256, 4'd0, 8'd3},
        '{2'd0, 10'd0,   4'd0, 8'd3},
        '{2'd0, 10'd128, 4'd0, 8'd2},
        '{2'd0, 10'd77,  4'd2, 8'd4},
        '{2'd0, 10'd200, 4'd1, 8'd4},
        '{2'd1, 10'd0,   4'd0, 8'd2},
        '{2'd1, 10'd511, 4'd0, 8'd2},
        '{2'd2, 10'd0,   4'd0, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic [15:0] result;
    logic result_valid;

    int checks = 0;
    int fails = 0;
    int valid_count = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    incr_decim2 uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .bit_valid    (bit_valid),
        .bit_in       (bit_in),
        .result       (result),
        .result_valid (result_valid)
    );

    always @(negedge clk) if (result_valid) valid_count++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pat_bit(input int mode, input int param, input int i);
        case (mode)
            0: return (((i + 1) * param) / 256 - (i * param) / 256) != 0;
            1: return i == param;
            default: return i != param;
        endcase
    endfunction

    function automatic int expect_q(input int mode, input int param);
        longint w = 0;
        for (int i = 0; i < LEN; i++) if (pat_bit(mode, param, i)) w += longint'(LEN - i);
        return int'((w * 32768) / FS);
    endfunction

    task automatic do_start(input bit with_bit);
        @(negedge clk);
        start = 1'b1;
        bit_valid = with_bit;
        bit_in = with_bit;
        @(negedge clk);
        start = 1'b0;
        bit_valid = 1'b0;
    endtask

    task automatic send_bits(input int mode, input int param, input int gap, input int first, input int count);
        for (int i = first; i < first + count; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in = pat_bit(mode, param, i);
            if (i != first + count - 1)
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    bit_valid = 1'b0;
                end
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    // Called at the negedge right after the edge that accepted the final bit.
    task automatic wait_valid(output int lat, output int res);
        lat = 0;
        res = -1;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk);
            #1;
            if (result_valid) begin
                lat = k;
                res = int'(result);
                break;
            end
        end
        @(posedge clk);
        #1;
        chk(!result_valid, "R5 pulse width", int'(result_valid), 0);
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        int lat;
        int res;
        int vc;
        int held;

        repeat (3) @(negedge clk);
        chk(result == 16'd0 && result_valid == 1'b0, "R1 reset state", int'(result), 0);
        rst_n = 1'b1;
        idle_cycles(2);
        chk(result == 16'd0 && result_valid == 1'b0, "R1 after release", int'(result), 0);

        // Table walk: R2, R3, R4, R9 under several bit patterns.
        for (int v = 0; v < NVEC; v++) begin
            do_start(1'b0);
            send_bits(int'(VECS[v].mode), int'(VECS[v].param), int'(VECS[v].gap), 0, LEN);
            wait_valid(lat, res);
            chk(res == expect_q(int'(VECS[v].mode), int'(VECS[v].param)),
                $sformatf("R%0d/R2/R9 vector %0d value", VECS[v].req, v), res,
                expect_q(int'(VECS[v].mode), int'(VECS[v].param)));
            chk(lat == LATENCY, $sformatf("R5 vector %0d latency", v), lat, LATENCY);
        end

        // R6: bits while idle are ignored, result held.
        held = int'(result);
        vc = valid_count;
        send_bits(0, 128, 0, 0, 600);
        idle_cycles(30);
        chk(valid_count == vc, "R6 idle bits produce no result", valid_count, vc);
        chk(int'(result) == held, "R6 result held", int'(result), held);

        // R4: N-1 bits give nothing; the Nth completes.
        do_start(1'b0);
        vc = valid_count;
        send_bits(0, 256, 0, 0, LEN - 1);
        idle_cycles(30);
        chk(valid_count == vc, "R4 short conversion no result", valid_count, vc);
        send_bits(0, 256, 0, LEN - 1, 1);
        wait_valid(lat, res);
        chk(res == 32768, "R4 completion after final bit", res, 32768);
        chk(lat == LATENCY, "R4 latency after gap", lat, LATENCY);

        // R7: abort during accumulation.
        do_start(1'b0);
        vc = valid_count;
        send_bits(0, 256, 0, 0, 100);
        do_start(1'b0);
        send_bits(0, 0, 0, 0, LEN);
        wait_valid(lat, res);
        chk(res == 0, "R7 abort in accumulation value", res, 0);
        chk(valid_count == vc + 1, "R7 single result", valid_count, vc + 1);

        // R7: abort during division.
        held = int'(result);
        do_start(1'b0);
        send_bits(0, 256, 0, 0, LEN);
        idle_cycles(4);
        vc = valid_count;
        do_start(1'b0);
        idle_cycles(40);
        chk(valid_count == vc, "R7 abort in division no result", valid_count, vc);
        chk(int'(result) == held, "R7 abort in division result held", int'(result), held);
        send_bits(0, 128, 0, 0, LEN);
        wait_valid(lat, res);
        chk(res == expect_q(0, 128), "R7 restart value", res, expect_q(0, 128));

        // R8: start with a simultaneous valid bit drops that bit.
        do_start(1'b1);
        send_bits(0, 0, 0, 0, LEN);
        wait_valid(lat, res);
        chk(res == 0, "R8 coincident bit dropped value", res, 0);
        chk(lat == LATENCY, "R8 coincident bit dropped latency", lat, LATENCY);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule